// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a byte-wide asynchronous serial transmitter and receiver that software drives through a small 32-bit register bus. Bytes written by software queue in a transmit FIFO and are shifted out on `tx_o`. Bytes arriving on `rx_i` are framed, checked and queued in a receive FIFO, where software reads them one at a time. The FIFO status travels in bit 31 of each data register, so a single bus access both moves data and reports whether it succeeded.

A 16-bit divisor sets the bit time to divisor plus one clock cycles. Frames have one start bit, eight data bits sent least significant bit first, no parity, and one or two stop bits. Each direction has its own enable and its own 3-bit FIFO-level threshold. The two thresholds raise two pending bits, and an enable mask merges those bits into one interrupt line. Software typically programs the threshold so the interrupt fires when the transmit queue needs refilling, or as soon as any byte arrives.

Register offsets: 0x00 send data, 0x04 receive data, 0x08 transmit config, 0x0C receive config, 0x10 interrupt mask, 0x14 interrupt status, 0x18 bit-time divisor. The bus address is compared in full, and an address that matches none of these reads as zero and ignores writes.

Top module: `wuart`

## Requirements
- R1: After reset, `tx_o` is high and `irq` is low. Every config, mask, status and divisor register reads zero. A read of offset 0x04 returns 0x8000_0000.
- R2: A write to offset 0x00 queues `bus_wdata[7:0]` when the transmit FIFO holds fewer than 8 bytes, and is dropped otherwise. A read of 0x00 returns bit 31 set exactly when 8 bytes are queued, with all other bits zero.
- R3: A frame starts one clock after the transmitter is idle and finds a queued byte, and the byte leaves the FIFO on that same clock edge. The frame sends a low start bit, then data bits 0 through 7, then one high stop bit, or two when bit 1 of offset 0x08 is set. Every bit lasts DIV+1 clocks, where DIV is bits 15:0 of offset 0x18. The line is high whenever no frame is in progress.
- R4: Bit 0 of offset 0x08 enables transmission. While it is clear, no new frame starts, queued bytes stay queued and `tx_o` stays high.
- R5: The receiver finds the falling edge of a start bit on `rx_i` and samples each bit near its middle. It queues the byte of each valid frame. A read of 0x04 returns the oldest byte in bits 7:0 with bit 31 clear, and removes that byte. Reception needs DIV of at least 1.
- R6: A read of 0x04 with an empty receive FIFO returns 0x8000_0000 and removes nothing. A frame that arrives while 8 bytes are queued is dropped.
- R7: Bit 0 of offset 0x0C enables reception. A frame that completes while this bit is clear is not stored.
- R8: A frame whose stop bit samples low is dropped.
- R9: Status bit 0 (offset 0x14) is set while the transmit FIFO holds fewer bytes than bits 18:16 of offset 0x08. With a threshold of 0 it is never set.
- R10: Status bit 1 is set while the receive FIFO holds more bytes than bits 18:16 of offset 0x0C.
- R11: `irq` is the OR of the status bits that are set in bits 1:0 of offset 0x10. Bit 0 is transmit and bit 1 is receive.
- R12: The config registers read back what was written. Offset 0x08 returns enable in bit 0, stop select in bit 1 and threshold in bits 18:16. Offset 0x0C returns enable in bit 0 and threshold in bits 18:16. Offset 0x10 returns bits 1:0. Offset 0x18 returns bits 15:0. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; a read of 0x04 consumes a byte |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Masked watermark interrupt |
| tx_o | output | 1 | Serial transmit line, idles high |
| rx_i | input | 1 | Serial receive line, idles high |

## Verification
The checker watches the following on every clock cycle:
- FIFO occupancy stays within its bound.
- A write to a full transmit queue does not grow it.
- The transmit line is high whenever the serializer is idle.
- A read of an empty receive queue carries the empty flag.
- The receive count never grows while reception is disabled.
- `irq` stays low when its mask bits forbid it.

Other behaviours need the bench's scenarios and its clock-by-clock model:
- the exact bit timing and stop-bit count on `tx_o`;
- the one-clock start latency after a byte is queued;
- the watermark thresholds at each FIFO level;
- rejection of frames with a bad stop bit;
- the byte order out of the receive FIFO.

// File: rtl/wuart_pkg.sv
package wuart_pkg;
    localparam int unsigned OFS_SEND   = 32'h00;
    localparam int unsigned OFS_RECV   = 32'h04;
    localparam int unsigned OFS_TXCFG  = 32'h08;
    localparam int unsigned OFS_RXCFG  = 32'h0C;
    localparam int unsigned OFS_MASK   = 32'h10;
    localparam int unsigned OFS_STAT   = 32'h14;
    localparam int unsigned OFS_DIV    = 32'h18;
    localparam int unsigned WM_LSB     = 16;
    localparam int unsigned CHAR_W     = 8;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_phase_e;
endpackage

// File: rtl/wuart_fifo.sv
module wuart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_q, s_d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (s_q.cnt == CNT_W'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wr = step(s_q.wr);
        if (do_pop)  s_d.rd = step(s_q.rd);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wr] <= wdata;
    end

    assign rdata = mem[s_q.rd];
    assign count = s_q.cnt;
endmodule

// File: rtl/wuart_tx.sv
module wuart_tx #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              two_stop,
    input  logic [DIV_W-1:0]  div,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              line,
    output logic              busy
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int NB_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] shreg;
        logic [NB_W-1:0]    nbits;
        logic [DIV_W-1:0]   cnt;
    } tx_state_t;

    tx_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        pop = 1'b0;
        if (!s_q.busy) begin
            if (en && !fifo_empty) begin
                pop       = 1'b1;
                s_d.busy  = 1'b1;
                s_d.shreg = {2'b11, fifo_data, 1'b0};
                s_d.nbits = two_stop ? NB_W'(FRAME_W) : NB_W'(FRAME_W - 1);
                s_d.cnt   = div;
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (s_q.nbits == NB_W'(1)) begin
            s_d.busy = 1'b0;
        end else begin
            s_d.shreg = {1'b1, s_q.shreg[FRAME_W-1:1]};
            s_d.nbits = s_q.nbits - 1'b1;
            s_d.cnt   = div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line = s_q.busy ? s_q.shreg[0] : 1'b1;
    assign busy = s_q.busy;
endmodule

// File: rtl/wuart_rx.sv
module wuart_rx
    import wuart_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    output logic              push,
    output logic [DATA_W-1:0] data
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        rx_phase_e         phase;
        logic              prev;
        logic [DIV_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] shreg;
    } rx_state_t;

    localparam rx_state_t RX_RST = '{phase: RX_IDLE, prev: 1'b1, cnt: '0, bitn: '0, shreg: '0};

    rx_state_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.prev = line;
        push     = 1'b0;
        case (s_q.phase)
            RX_IDLE: begin
                if (s_q.prev && !line) begin
                    s_d.phase = RX_START;
                    s_d.cnt   = div >> 1;
                end
            end
            RX_START: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (line) begin
                    s_d.phase = RX_IDLE;
                end else begin
                    s_d.phase = RX_DATA;
                    s_d.cnt   = div;
                    s_d.bitn  = '0;
                end
            end
            RX_DATA: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.shreg = {line, s_q.shreg[DATA_W-1:1]};
                    s_d.cnt   = div;
                    if (s_q.bitn == BIT_W'(DATA_W - 1)) s_d.phase = RX_STOP;
                    else                                s_d.bitn  = s_q.bitn + 1'b1;
                end
            end
            RX_STOP: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.phase = RX_IDLE;
                    push      = line && en;
                end
            end
            default: s_d.phase = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RX_RST;
        else        s_q <= s_d;
    end

    assign data = s_q.shreg;
endmodule

// File: rtl/wuart.sv
module wuart
    import wuart_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 16,
    parameter int WM_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              tx_o,
    input  logic              rx_i
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic             tx_en;
        logic             two_stop;
        logic [WM_W-1:0]  tx_wm;
        logic             rx_en;
        logic [WM_W-1:0]  rx_wm;
        logic [1:0]       ie;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t regs_q, regs_d;

    logic sel_send, sel_recv, sel_txcfg, sel_rxcfg, sel_mask, sel_stat, sel_div;
    logic tx_full, tx_empty, tx_pop, tx_busy;
    logic rx_full, rx_empty, rx_push, rx_pop;
    logic [CHAR_W-1:0] tx_head, rx_head, rx_byte;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic [1:0] ip;
    logic [1:0] ie_w;
    logic [WM_W-1:0] tx_wm_w;
    logic rx_en_w;
    logic unused_bits;

    assign sel_send  = (bus_addr == ADDR_W'(OFS_SEND));
    assign sel_recv  = (bus_addr == ADDR_W'(OFS_RECV));
    assign sel_txcfg = (bus_addr == ADDR_W'(OFS_TXCFG));
    assign sel_rxcfg = (bus_addr == ADDR_W'(OFS_RXCFG));
    assign sel_mask  = (bus_addr == ADDR_W'(OFS_MASK));
    assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
    assign sel_div   = (bus_addr == ADDR_W'(OFS_DIV));

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            if (sel_txcfg) begin
                regs_d.tx_en    = bus_wdata[0];
                regs_d.two_stop = bus_wdata[1];
                regs_d.tx_wm    = bus_wdata[WM_LSB +: WM_W];
            end
            if (sel_rxcfg) begin
                regs_d.rx_en = bus_wdata[0];
                regs_d.rx_wm = bus_wdata[WM_LSB +: WM_W];
            end
            if (sel_mask) regs_d.ie  = bus_wdata[1:0];
            if (sel_div)  regs_d.div = bus_wdata[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rx_pop = bus_re && sel_recv && !rx_empty;

    assign ip[0] = 32'(tx_count) < 32'(regs_q.tx_wm);
    assign ip[1] = 32'(rx_count) > 32'(regs_q.rx_wm);
    assign irq   = |(regs_q.ie & ip);

    always_comb begin
        bus_rdata = '0;
        if (sel_send) bus_rdata[31] = tx_full;
        if (sel_recv) begin
            bus_rdata[31] = rx_empty;
            if (!rx_empty) bus_rdata[CHAR_W-1:0] = rx_head;
        end
        if (sel_txcfg) begin
            bus_rdata[0]              = regs_q.tx_en;
            bus_rdata[1]              = regs_q.two_stop;
            bus_rdata[WM_LSB +: WM_W] = regs_q.tx_wm;
        end
        if (sel_rxcfg) begin
            bus_rdata[0]              = regs_q.rx_en;
            bus_rdata[WM_LSB +: WM_W] = regs_q.rx_wm;
        end
        if (sel_mask) bus_rdata[1:0]       = regs_q.ie;
        if (sel_stat) bus_rdata[1:0]       = ip;
        if (sel_div)  bus_rdata[DIV_W-1:0] = regs_q.div;
    end

    wuart_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (bus_we && sel_send),
        .wdata (bus_wdata[CHAR_W-1:0]),
        .pop   (tx_pop),
        .rdata (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    wuart_tx #(.DIV_W(DIV_W), .DATA_W(CHAR_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (regs_q.tx_en),
        .two_stop   (regs_q.two_stop),
        .div        (regs_q.div),
        .fifo_empty (tx_empty),
        .fifo_data  (tx_head),
        .pop        (tx_pop),
        .line       (tx_o),
        .busy       (tx_busy)
    );

    wuart_rx #(.DIV_W(DIV_W), .DATA_W(CHAR_W)) u_des (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (rx_i),
        .en    (regs_q.rx_en),
        .div   (regs_q.div),
        .push  (rx_push),
        .data  (rx_byte)
    );

    wuart_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign ie_w        = regs_q.ie;
    assign tx_wm_w     = regs_q.tx_wm;
    assign rx_en_w     = regs_q.rx_en;
    assign unused_bits = ^{bus_wdata, rx_full};
endmodule

// File: rtl/wuart_chk.sv
module wuart_chk #(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 4,
    parameter int WM_W       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              tx_o,
    input logic              tx_busy,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic [1:0]        ie,
    input logic [WM_W-1:0]   tx_wm,
    input logic              rx_en
);
    import wuart_pkg::*;

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(FIFO_DEPTH)) && (rx_count <= CNT_W'(FIFO_DEPTH)));

    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == CNT_W'(FIFO_DEPTH) && bus_we && bus_addr == ADDR_W'(OFS_SEND))
        |=> (tx_count == CNT_W'(FIFO_DEPTH) || tx_count == CNT_W'(FIFO_DEPTH - 1)));

    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_o);

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0 && bus_re && bus_addr == ADDR_W'(OFS_RECV))
        |-> (bus_rdata[31] && bus_rdata[7:0] == 8'h00));

    p_rx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (rx_count <= $past(rx_count)));

    p_txwm_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wm == '0 && ie == 2'b01) |-> !irq);

    p_mask_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 2'b00) |-> !irq);
endmodule

bind wuart wuart_chk #(
    .ADDR_W     (ADDR_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .WM_W       (WM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tx_o      (tx_o),
    .tx_busy   (tx_busy),
    .tx_count  (tx_count),
    .rx_count  (rx_count),
    .ie        (ie_w),
    .tx_wm     (tx_wm_w),
    .rx_en     (rx_en_w)
);

// File: tb/tb_wuart.sv
module tb_wuart;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq, tx_o;
    logic        rx_i = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit rx_busy = 1'b0;

    // behavioural reference state
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    bit          m_busy = 1'b0;
    int          m_cyc = 0;
    int          m_nb = 10;
    logic [10:0] m_frame = '1;
    bit          m_txen = 0, m_two = 0, m_rxen = 0;
    int          m_txwm = 0, m_rxwm = 0, m_div = 0;
    logic [1:0]  m_ie = 2'b00;

    always #2 clk = ~clk;

    wuart dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .tx_o      (tx_o),
        .rx_i      (rx_i)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] m_ip();
        return {rxq.size() > m_rxwm, txq.size() < m_txwm};
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] v = '0;
        case (a)
            8'h00: v[31] = (txq.size() == 8);
            8'h04: v = (rxq.size() == 0) ? 32'h8000_0000 : {24'h0, rxq[0]};
            8'h08: v = {13'h0, 3'(m_txwm), 14'h0, m_two, m_txen};
            8'h0C: v = {13'h0, 3'(m_rxwm), 15'h0, m_rxen};
            8'h10: v = {30'h0, m_ie};
            8'h14: v = {30'h0, m_ip()};
            8'h18: v = {16'h0, 16'(m_div)};
            default: v = '0;
        endcase
        return v;
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        int sz;
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_busy = 0; m_cyc = 0; m_txen = 0; m_two = 0; m_rxen = 0;
            m_txwm = 0; m_rxwm = 0; m_div = 0; m_ie = 2'b00;
        end else begin
            sz = txq.size();
            if (m_busy) begin
                m_cyc++;
                if (m_cyc == m_nb * (m_div + 1)) m_busy = 0;
            end else if (m_txen && sz > 0) begin
                m_frame = {2'b11, txq.pop_front(), 1'b0};
                m_nb    = m_two ? 11 : 10;
                m_busy  = 1;
                m_cyc   = 0;
            end
            if (bus_we && bus_addr == 8'h00 && sz < 8) txq.push_back(bus_wdata[7:0]);
            if (bus_re && bus_addr == 8'h04 && rxq.size() > 0) void'(rxq.pop_front());
            if (bus_we) begin
                case (bus_addr)
                    8'h08: begin m_txen = bus_wdata[0]; m_two = bus_wdata[1]; m_txwm = int'(bus_wdata[18:16]); end
                    8'h0C: begin m_rxen = bus_wdata[0]; m_rxwm = int'(bus_wdata[18:16]); end
                    8'h10: m_ie = bus_wdata[1:0];
                    8'h18: m_div = int'(bus_wdata[15:0]);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        #0.5;
        if (rst_n && !done) begin
            check("R3 R4 tx line", {31'h0, tx_o},
                  {31'h0, m_busy ? m_frame[m_cyc / (m_div + 1)] : 1'b1});
            if (!rx_busy)
                check("R9 R10 R11 irq", {31'h0, irq}, {31'h0, |(m_ie & m_ip())});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_addr = a; bus_re = 1'b1;
        #1;
        check(tag, bus_rdata, exp_read(a));
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] b, input bit stop_ok);
        rx_busy = 1'b1;
        for (int i = 0; i < 10; i++) begin
            rx_i = (i == 0) ? 1'b0 : (i == 9) ? stop_ok : b[i-1];
            repeat (m_div + 1) @(negedge clk);
        end
        rx_i = 1'b1;
        if (stop_ok && m_rxen && rxq.size() < 8) rxq.push_back(b);
        repeat (m_div + 1) @(negedge clk);
        rx_busy = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R12: reset state of every register
        check("R1 tx idle", {31'h0, tx_o}, 32'h1);
        check("R1 irq low", {31'h0, irq}, 32'h0);
        rd(8'h00, "R1 send");
        rd(8'h04, "R1 recv empty");
        rd(8'h08, "R1 txcfg");
        rd(8'h0C, "R1 rxcfg");
        rd(8'h10, "R1 mask");
        rd(8'h14, "R1 status");
        rd(8'h18, "R1 div");
        rd(8'h1C, "R12 unmapped");

        // R3: one stop bit, DIV=3
        wr(8'h18, 32'd3);
        wr(8'h08, (32'd1 << 16) | 32'h1);
        wr(8'h10, 32'h1);
        rd(8'h08, "R12 txcfg readback");
        rd(8'h14, "R9 status empty");
        wr(8'h00, 32'hA5);
        wr(8'h00, 32'h3C);
        wr(8'h00, 32'h01);
        rd(8'h14, "R9 status queued");
        idle(150);

        // R3: two stop bits, DIV=5
        wr(8'h18, 32'd5);
        wr(8'h08, (32'd1 << 16) | 32'h3);
        wr(8'h00, 32'h96);
        wr(8'h00, 32'hFF);
        idle(150);
        rd(8'h18, "R12 div readback");

        // R2 R4: disabled transmitter, fill past capacity
        wr(8'h08, (32'd7 << 16));
        for (int i = 0; i < 9; i++) wr(8'h00, 32'(8'h40 + i));
        rd(8'h00, "R2 full flag");
        rd(8'h14, "R9 status at full");
        idle(50);
        wr(8'h08, (32'd7 << 16) | 32'h1);
        idle(8);
        rd(8'h00, "R2 not full after start");
        idle(560);

        // R9: threshold zero never pends
        wr(8'h08, 32'h1);
        rd(8'h14, "R9 zero threshold");

        // R5 R10: reception with threshold 1
        wr(8'h18, 32'd4);
        wr(8'h0C, (32'd1 << 16) | 32'h1);
        wr(8'h10, 32'h2);
        rd(8'h0C, "R12 rxcfg readback");
        frame(8'h5A, 1'b1);
        rd(8'h14, "R10 one byte");
        frame(8'hC3, 1'b1);
        rd(8'h14, "R10 two bytes");
        idle(3);
        rd(8'h04, "R5 first byte");
        rd(8'h04, "R5 second byte");
        rd(8'h04, "R6 empty read");
        rd(8'h04, "R6 empty read again");

        // R7: reception disabled
        wr(8'h0C, 32'h0);
        frame(8'h77, 1'b1);
        rd(8'h04, "R7 nothing stored");

        // R8: bad stop bit, then a good frame
        wr(8'h0C, 32'h1);
        frame(8'h11, 1'b0);
        rd(8'h04, "R8 bad stop dropped");
        frame(8'h22, 1'b1);
        rd(8'h04, "R8 good after bad");

        // R6: overflow of the receive FIFO
        for (int i = 0; i < 9; i++) frame(8'(8'h80 + i), 1'b1);
        rd(8'h14, "R10 status full");
        for (int i = 0; i < 9; i++) rd(8'h04, "R6 overflow drain");

        // R11: mask both, transmit threshold pending
        wr(8'h08, (32'd2 << 16) | 32'h1);
        wr(8'h10, 32'h3);
        idle(4);
        check("R11 irq both masked", {31'h0, irq}, 32'h1);
        wr(8'h10, 32'h0);
        idle(2);
        check("R11 irq unmasked off", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule